// File: doc/BRIEF.md
# Serial Port Clock and Frame Generator

This block produces the timing for a synchronous serial port that runs from its own internal clock. A chain of dividers takes the core clock down to a 50% duty bit clock: an optional fixed divide-by-8, a programmable modulus divider of 1 to 256, and a fixed divide-by-4. The bit clock is then counted into words of 8, 10, 12 or 16 bits, and the words are counted into frames of 1 to 32 words. The outputs are the bit clock, one-cycle strobes on its rising and falling edges, word and frame start strobes, and a frame-sync pulse. The sync pulse lasts either one full word or a single bit.

The control fields are sampled when the block is enabled and again at each frame boundary. Changes made in the middle of a frame therefore never disturb a frame in progress. In network mode, a frame of a single word is not a legal setting. The block raises an error flag for that setting and stays silent until the setting becomes legal.

The controller has three states. `ST_IDLE` means disabled. `ST_RUN` means generating. `ST_HALT` means the setting is illegal and nothing is generated.

The transitions are:
- `T_START`: from IDLE to RUN, when enabled with a legal setting.
- `T_START_BAD`: from IDLE to HALT, when enabled with an illegal setting.
- `T_WRAP_BAD`: from RUN to HALT, at a frame boundary where the new setting is illegal.
- `T_RECOVER`: from HALT to RUN, once the setting becomes legal.
- `T_STOP`: from RUN or HALT to IDLE, when the enable goes low.
- In all other cases the controller stays in its current state.

Top module: `sclk_frame_gen`

## Requirements
- R1: The bit clock period is 4 × D × (M+1) core cycles, where M is `cfg_modulus` and D is 1. The clock is high for exactly half of each period, measured between the `bit_rise` and `bit_fall` strobes.
- R2: When `cfg_range_x8` is 1, D is 8, so the period becomes 32 × (M+1) cycles. The slowest period is 8192 cycles, with M = 255.
- R3: `cfg_wlen` sets the bits per word: 2'b00 gives 8, 2'b01 gives 10, 2'b10 gives 12 and 2'b11 gives 16. `word_start` pulses on the rising edge that starts each word.
- R4: Each frame holds `cfg_frame_div`+1 words, from 1 to 32, in both modes. `frame_start` pulses on the rising edge of the first bit of the first word, and the first rising edge after enabling starts a frame.
- R5: When `cfg_network`=1 and `cfg_frame_div`=0, the block enters HALT and asserts `cfg_error`. While in HALT, `bit_clk`, all strobes and `frame_sync` stay at 0. It leaves HALT one cycle after the setting becomes legal.
- R6: When `cfg_sync_short`=0, `frame_sync` is high for the whole first word of each frame, which is one word length of bit periods.
- R7: When `cfg_sync_short`=1, `frame_sync` is high for exactly the first bit period of each frame.
- R8: `frame_sync`, `word_start` and `frame_start` change only in the cycle where `bit_rise` pulses. `bit_rise` pulses in the first cycle that `bit_clk` is high, and `bit_fall` pulses in the first cycle that it is low.
- R9: A control change made mid-frame takes effect starting with the bit at the next frame boundary. If the new setting is illegal, no rising edge is produced at that boundary and the block enters HALT.
- R10: One cycle after `enable` goes low, all outputs are 0. Re-enabling restarts from a fresh frame with the current settings.
- R11: While `rst_n` is low, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Runs the generator; when low, all counters are cleared |
| cfg_range_x8 | input | 1 | Inserts the fixed divide-by-8 stage |
| cfg_modulus | input | 8 | Prescale modulus M; the divide ratio is M+1 |
| cfg_wlen | input | 2 | Word-length code |
| cfg_frame_div | input | 5 | Frame divider; the frame holds this value + 1 words |
| cfg_network | input | 1 | 1 selects network mode, 0 selects normal mode |
| cfg_sync_short | input | 1 | 1 gives a one-bit sync pulse, 0 gives a one-word sync pulse |
| bit_clk | output | 1 | Bit clock |
| bit_rise | output | 1 | Strobe in the first cycle `bit_clk` is high |
| bit_fall | output | 1 | Strobe in the first cycle `bit_clk` is low |
| word_start | output | 1 | Strobe on the rising edge that starts a word |
| frame_start | output | 1 | Strobe on the rising edge that starts a frame |
| frame_sync | output | 1 | Frame-sync pulse |
| cfg_error | output | 1 | Illegal network-mode setting is selected |

## Verification
The hardest situation to reach from the ports is a frame boundary where the settings have changed mid-frame. This covers both a legal change, whose new period and word length must start exactly at the boundary bit, and a change to an illegal network setting, which must suppress the boundary edge and enter HALT. The stimulus waits for a `frame_start` and then rewrites the control inputs at once. An independent model in the bench predicts the bit and word position from the old settings up to the wrap. The bench then counts the rising edges that appear before `cfg_error` and checks the period and the word length that follow the boundary.

// File: rtl/sclk_frame_pkg.sv
package sclk_frame_pkg;

    localparam int MOD_W   = 8;
    localparam int WL_W    = 2;
    localparam int DC_W    = 5;
    localparam int MAX_BPW = 16;
    localparam int BI_W    = $clog2(MAX_BPW);

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_HALT = 2'd2
    } ctl_state_e;

    typedef struct packed {
        logic             range_x8;
        logic [MOD_W-1:0] modulus;
        logic [WL_W-1:0]  wlen;
        logic [DC_W-1:0]  frame_div;
        logic             network;
        logic             sync_short;
    } gen_cfg_t;

    function automatic logic [BI_W:0] bits_per_word(input logic [WL_W-1:0] code);
        logic [BI_W:0] n;
        unique case (code)
            2'b00:   n = (BI_W+1)'(8);
            2'b01:   n = (BI_W+1)'(10);
            2'b10:   n = (BI_W+1)'(12);
            default: n = (BI_W+1)'(16);
        endcase
        return n;
    endfunction

    function automatic logic cfg_is_illegal(input gen_cfg_t c);
        return c.network && (c.frame_div == '0);
    endfunction

endpackage

// File: rtl/sclk_prescale.sv
module sclk_prescale #(
    parameter int MOD_W     = 8,
    parameter int RANGE_DIV = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             range_x8,
    input  logic [MOD_W-1:0] modulus,
    output logic             half_tick
);
    localparam int R_W = (RANGE_DIV > 1) ? $clog2(RANGE_DIV) : 1;
    localparam logic [R_W-1:0] R_LAST = R_W'(RANGE_DIV - 1);

    logic [R_W-1:0]   fix_cnt_q;
    logic [MOD_W-1:0] mod_cnt_q;
    logic             pair_q;
    logic             fix_tick;
    logic             mod_tick;

    // stage 1: optional fixed divider
    assign fix_tick = !range_x8 || (fix_cnt_q == R_LAST);
    // stage 2: modulus divider (M+1)
    assign mod_tick = fix_tick && (mod_cnt_q == modulus);
    // stage 3: divide by two; the toggle in the framer gives the last /2
    assign half_tick = mod_tick && pair_q;

    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            fix_cnt_q <= '0;
            mod_cnt_q <= '0;
            pair_q    <= 1'b0;
        end else begin
            if (range_x8) begin
                fix_cnt_q <= (fix_cnt_q == R_LAST) ? '0 : fix_cnt_q + 1'b1;
            end else begin
                fix_cnt_q <= '0;
            end
            if (fix_tick) begin
                mod_cnt_q <= (mod_cnt_q == modulus) ? '0 : mod_cnt_q + 1'b1;
            end
            if (mod_tick) begin
                pair_q <= ~pair_q;
            end
        end
    end

endmodule

// File: rtl/sclk_framer.sv
module sclk_framer #(
    parameter int BI_W = 4,
    parameter int DC_W = 5
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clear,
    input  logic            half_tick,
    input  logic [BI_W-1:0] last_bit,
    input  logic [DC_W-1:0] last_word,
    input  logic            sync_short,
    output logic            wrap_pending,
    output logic            bit_clk,
    output logic            bit_rise,
    output logic            bit_fall,
    output logic            word_start,
    output logic            frame_start,
    output logic            frame_sync
);
    logic            clk_q, rise_q, fall_q, wst_q, fst_q, sync_q, started_q;
    logic [BI_W-1:0] bi_q, bi_d;
    logic [DC_W-1:0] wi_q, wi_d;
    logic            rise_evt, fall_evt;

    assign rise_evt = half_tick && !clk_q;
    assign fall_evt = half_tick && clk_q;
    assign wrap_pending = rise_evt && started_q && (bi_q == last_bit) && (wi_q == last_word);

    always_comb begin
        if (!started_q) begin
            bi_d = '0;
            wi_d = '0;
        end else if (bi_q == last_bit) begin
            bi_d = '0;
            wi_d = (wi_q == last_word) ? '0 : wi_q + 1'b1;
        end else begin
            bi_d = bi_q + 1'b1;
            wi_d = wi_q;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            clk_q     <= 1'b0;
            rise_q    <= 1'b0;
            fall_q    <= 1'b0;
            wst_q     <= 1'b0;
            fst_q     <= 1'b0;
            sync_q    <= 1'b0;
            started_q <= 1'b0;
            bi_q      <= '0;
            wi_q      <= '0;
        end else begin
            rise_q <= rise_evt;
            fall_q <= fall_evt;
            wst_q  <= 1'b0;
            fst_q  <= 1'b0;
            if (half_tick) begin
                clk_q <= ~clk_q;
            end
            if (rise_evt) begin
                started_q <= 1'b1;
                bi_q      <= bi_d;
                wi_q      <= wi_d;
                wst_q     <= (bi_d == '0);
                fst_q     <= (bi_d == '0) && (wi_d == '0);
                sync_q    <= (wi_d == '0) && (!sync_short || (bi_d == '0));
            end
        end
    end

    assign bit_clk     = clk_q;
    assign bit_rise    = rise_q;
    assign bit_fall    = fall_q;
    assign word_start  = wst_q;
    assign frame_start = fst_q;
    assign frame_sync  = sync_q;

endmodule

// File: rtl/sclk_frame_gen.sv
module sclk_frame_gen
    import sclk_frame_pkg::*;
#(
    parameter int RANGE_DIV = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic             cfg_range_x8,
    input  logic [MOD_W-1:0] cfg_modulus,
    input  logic [WL_W-1:0]  cfg_wlen,
    input  logic [DC_W-1:0]  cfg_frame_div,
    input  logic             cfg_network,
    input  logic             cfg_sync_short,
    output logic             bit_clk,
    output logic             bit_rise,
    output logic             bit_fall,
    output logic             word_start,
    output logic             frame_start,
    output logic             frame_sync,
    output logic             cfg_error
);
    ctl_state_e state_q, state_d;
    gen_cfg_t   cfg_in, act_cfg;
    logic       in_bad, load_cfg, run_ok, wrap_pending, half_tick;
    logic [BI_W:0]   bpw;
    logic [BI_W-1:0] last_bit;

    assign cfg_in = '{range_x8:   cfg_range_x8,
                      modulus:    cfg_modulus,
                      wlen:       cfg_wlen,
                      frame_div:  cfg_frame_div,
                      network:    cfg_network,
                      sync_short: cfg_sync_short};
    assign in_bad = cfg_is_illegal(cfg_in);

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (enable) state_d = in_bad ? ST_HALT : ST_RUN;   // T_START / T_START_BAD
            ST_RUN: begin
                if (!enable)                     state_d = ST_IDLE;      // T_STOP
                else if (wrap_pending && in_bad) state_d = ST_HALT;      // T_WRAP_BAD
            end
            ST_HALT: begin
                if (!enable)     state_d = ST_IDLE;                      // T_STOP
                else if (!in_bad) state_d = ST_RUN;                      // T_RECOVER
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // control outputs of the state machine
    always_comb begin
        run_ok    = (state_q == ST_RUN) && (state_d == ST_RUN);
        load_cfg  = (state_d == ST_RUN) &&
                    ((state_q != ST_RUN) || wrap_pending);
        cfg_error = (state_q == ST_HALT);
    end

    always_ff @(posedge clk) begin
        if (!rst_n)        act_cfg <= '0;
        else if (load_cfg) act_cfg <= cfg_in;
    end

    assign bpw      = bits_per_word(act_cfg.wlen);
    assign last_bit = BI_W'(bpw - 1'b1);

    sclk_prescale #(
        .MOD_W     (MOD_W),
        .RANGE_DIV (RANGE_DIV)
    ) u_prescale (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (!run_ok),
        .range_x8  (act_cfg.range_x8),
        .modulus   (act_cfg.modulus),
        .half_tick (half_tick)
    );

    sclk_framer #(
        .BI_W (BI_W),
        .DC_W (DC_W)
    ) u_framer (
        .clk          (clk),
        .rst_n        (rst_n),
        .clear        (!run_ok),
        .half_tick    (half_tick),
        .last_bit     (last_bit),
        .last_word    (act_cfg.frame_div),
        .sync_short   (act_cfg.sync_short),
        .wrap_pending (wrap_pending),
        .bit_clk      (bit_clk),
        .bit_rise     (bit_rise),
        .bit_fall     (bit_fall),
        .word_start   (word_start),
        .frame_start  (frame_start),
        .frame_sync   (frame_sync)
    );

endmodule

// File: rtl/sclk_frame_gen_chk.sv
module sclk_frame_gen_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       enable,
    input logic       cfg_network,
    input logic [4:0] cfg_frame_div,
    input logic       bit_clk,
    input logic       bit_rise,
    input logic       bit_fall,
    input logic       word_start,
    input logic       frame_start,
    input logic       frame_sync,
    input logic       cfg_error,
    input logic       act_range,
    input logic [7:0] act_mod,
    input logic       act_short
);
    logic [13:0] hi_cnt;
    logic [13:0] half_exp;

    assign half_exp = (14'(act_mod) + 14'd1) << (act_range ? 4 : 1);

    always_ff @(posedge clk) begin
        if (!rst_n)        hi_cnt <= '0;
        else if (bit_rise) hi_cnt <= 14'd1;
        else if (bit_clk)  hi_cnt <= hi_cnt + 14'd1;
    end

    a_r1_half_high: assert property (@(posedge clk) disable iff (!rst_n)
        bit_fall |-> (hi_cnt == half_exp));
    a_r8_rise_edge: assert property (@(posedge clk) disable iff (!rst_n)
        bit_rise |-> (bit_clk && !$past(bit_clk)));
    a_r8_fall_edge: assert property (@(posedge clk) disable iff (!rst_n)
        bit_fall |-> (!bit_clk && $past(bit_clk)));
    a_r8_strobe_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
        (word_start || frame_start) |-> bit_rise);
    a_r4_frame_is_word: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |-> word_start);
    a_r8_sync_moves_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && !cfg_error && !$stable(frame_sync) && $past(enable)) |-> bit_rise);
    a_r5_halt_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_error |-> (!bit_clk && !bit_rise && !frame_sync && !word_start));
    a_r5_error_cause: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_error |-> $past(cfg_network && (cfg_frame_div == 5'd0)));
    a_r10_disable_clears: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (!bit_clk && !frame_sync && !cfg_error && !bit_rise && !word_start));
    a_r7_short_sync: assert property (@(posedge clk) disable iff (!rst_n)
        (act_short && bit_rise && !frame_start) |-> !frame_sync);
    a_r6_long_sync: assert property (@(posedge clk) disable iff (!rst_n)
        (!act_short && word_start) |-> (frame_sync == frame_start));

endmodule

bind sclk_frame_gen sclk_frame_gen_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .enable        (enable),
    .cfg_network   (cfg_network),
    .cfg_frame_div (cfg_frame_div),
    .bit_clk       (bit_clk),
    .bit_rise      (bit_rise),
    .bit_fall      (bit_fall),
    .word_start    (word_start),
    .frame_start   (frame_start),
    .frame_sync    (frame_sync),
    .cfg_error     (cfg_error),
    .act_range     (act_cfg.range_x8),
    .act_mod       (act_cfg.modulus),
    .act_short     (act_cfg.sync_short)
);

// File: tb/sclk_frame_gen_bench.sv
`timescale 1ns/1ps
module sclk_frame_gen_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       enable = 1'b0;
    logic       cfg_range_x8 = 1'b0;
    logic [7:0] cfg_modulus = '0;
    logic [1:0] cfg_wlen = '0;
    logic [4:0] cfg_frame_div = '0;
    logic       cfg_network = 1'b0;
    logic       cfg_sync_short = 1'b0;
    logic bit_clk, bit_rise, bit_fall, word_start, frame_start, frame_sync, cfg_error;

    int checks = 0;
    int fails  = 0;
    int total_cyc = 0;

    always #10 clk = ~clk;   // 50 MHz

    sclk_frame_gen u_sclk_frame_gen (
        .clk(clk), .rst_n(rst_n), .enable(enable),
        .cfg_range_x8(cfg_range_x8), .cfg_modulus(cfg_modulus),
        .cfg_wlen(cfg_wlen), .cfg_frame_div(cfg_frame_div),
        .cfg_network(cfg_network), .cfg_sync_short(cfg_sync_short),
        .bit_clk(bit_clk), .bit_rise(bit_rise), .bit_fall(bit_fall),
        .word_start(word_start), .frame_start(frame_start),
        .frame_sync(frame_sync), .cfg_error(cfg_error)
    );

    always @(posedge clk) begin
        total_cyc <= total_cyc + 1;
        if (total_cyc > 195000) begin
            checks = checks + 1;
            fails  = fails + 1;
            $display("FAIL watchdog: run did not finish, actual=%0d expected<=195000", total_cyc);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    task automatic chk(input logic ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int wl_bits(input logic [1:0] c);
        case (c)
            2'b00: return 8;
            2'b01: return 10;
            2'b10: return 12;
            default: return 16;
        endcase
    endfunction

    task automatic set_cfg(input logic r, input logic [7:0] pm, input logic [1:0] wl,
                           input logic [4:0] dc, input logic net, input logic sh);
        cfg_range_x8 = r; cfg_modulus = pm; cfg_wlen = wl;
        cfg_frame_div = dc; cfg_network = net; cfg_sync_short = sh;
    endtask

    task automatic wait_frame(input int limit, output logic seen);
        seen = 1'b0;
        for (int i = 0; i < limit && !seen; i++) begin
            @(negedge clk);
            if (frame_start) seen = 1'b1;
        end
    endtask

    // R11: outputs quiet under reset
    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk({bit_clk, bit_rise, bit_fall, word_start, frame_start, frame_sync, cfg_error} == 7'd0,
            "R11 reset outputs", int'({bit_clk, frame_sync, cfg_error}), 0);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    // R1 R2 R3 R4 R6 R7 R8: measure period, duty, word and frame structure, sync width
    task automatic t_run(input logic r, input logic [7:0] pm, input logic [1:0] wl,
                         input logic [4:0] dc, input logic net, input logic sh, input int nrises);
        int h, w, f, cyc, last, bi, wi, seen_r;
        logic seen, exp_sync;
        string tp, ts;
        h  = 2 * (r ? 8 : 1) * (int'(pm) + 1);
        w  = wl_bits(wl);
        f  = int'(dc) + 1;
        tp = r ? "R2 period" : "R1 period";
        ts = sh ? "R7 sync" : "R6 sync";
        enable = 1'b0;
        set_cfg(r, pm, wl, dc, net, sh);
        repeat (2) @(negedge clk);
        enable = 1'b1;
        wait_frame(6 * h + 10, seen);
        chk(seen, "R4 first frame_start", int'(seen), 1);
        chk(frame_sync && !cfg_error, ts, int'(frame_sync), 1);
        cyc = 0; last = 0; bi = 0; wi = 0; seen_r = 0;
        while (seen && seen_r < nrises) begin
            @(negedge clk);
            cyc++;
            if (bit_fall) chk(cyc - last == h, "R1 high time", cyc - last, h);
            if (bit_rise) begin
                chk(cyc - last == 2 * h, tp, cyc - last, 2 * h);
                last = cyc;
                bi = (bi + 1) % w;
                if (bi == 0) wi = (wi + 1) % f;
                exp_sync = (wi == 0) && (!sh || bi == 0);
                chk(word_start == (bi == 0), "R3 word_start", int'(word_start), int'(bi == 0));
                chk(frame_start == (bi == 0 && wi == 0), "R4 frame_start",
                    int'(frame_start), int'(bi == 0 && wi == 0));
                chk(frame_sync == exp_sync, ts, int'(frame_sync), int'(exp_sync));
                seen_r++;
            end else if (word_start || frame_start) begin
                chk(1'b0, "R8 strobe without rise", 1, 0);
            end
        end
    endtask

    // R9: legal change mid-frame applies at the boundary
    task automatic t_midframe();
        int h, w, f, cyc, last, bi, wi, n;
        logic seen, sh, switched;
        enable = 1'b0;
        set_cfg(1'b0, 8'd0, 2'b00, 5'd1, 1'b0, 1'b0);
        repeat (2) @(negedge clk);
        enable = 1'b1;
        wait_frame(50, seen);
        chk(seen, "R9 start", int'(seen), 1);
        set_cfg(1'b0, 8'd1, 2'b01, 5'd2, 1'b0, 1'b1);
        h = 2; w = 8; f = 2; sh = 1'b0; switched = 1'b0;
        cyc = 0; last = 0; bi = 0; wi = 0; n = 0;
        while (seen && n < 60) begin
            @(negedge clk);
            cyc++;
            if (bit_rise) begin
                chk(cyc - last == 2 * h, "R9 period", cyc - last, 2 * h);
                last = cyc;
                bi = (bi + 1) % w;
                if (bi == 0) wi = (wi + 1) % f;
                if (bi == 0 && wi == 0 && !switched) begin
                    chk(frame_start == 1'b1, "R9 boundary frame_start", int'(frame_start), 1);
                    h = 4; w = 10; f = 3; sh = 1'b1; switched = 1'b1;
                end
                chk(word_start == (bi == 0), "R9 word length", int'(word_start), int'(bi == 0));
                chk(frame_sync == ((wi == 0) && (!sh || bi == 0)), "R9 sync",
                    int'(frame_sync), int'((wi == 0) && (!sh || bi == 0)));
                n++;
            end
        end
    endtask

    // R5: illegal network setting from enable, and at a frame wrap
    task automatic t_illegal();
        int rises, quiet;
        logic seen;
        enable = 1'b0;
        set_cfg(1'b0, 8'd0, 2'b00, 5'd0, 1'b1, 1'b0);
        repeat (2) @(negedge clk);
        enable = 1'b1;
        repeat (2) @(negedge clk);
        chk(cfg_error == 1'b1, "R5 error flag", int'(cfg_error), 1);
        quiet = 0;
        for (int i = 0; i < 200; i++) begin
            @(negedge clk);
            if (bit_rise || bit_clk || frame_sync) quiet++;
        end
        chk(quiet == 0, "R5 no activity in HALT", quiet, 0);
        cfg_frame_div = 5'd1;
        wait_frame(50, seen);
        chk(seen && !cfg_error, "R5 recover", int'(cfg_error), 0);
        // frame just started: 16 bits per frame, 15 rises left before the wrap
        cfg_frame_div = 5'd0;
        rises = 0;
        for (int i = 0; i < 200 && !cfg_error; i++) begin
            @(negedge clk);
            if (bit_rise) rises++;
        end
        chk(rises == 15, "R9 rises before HALT", rises, 15);
        chk(cfg_error && !bit_clk && !bit_rise, "R5 halt at wrap", int'(bit_clk), 0);
    endtask

    // R10: disable clears, re-enable restarts with current settings
    task automatic t_disable();
        int cyc, last, n;
        logic seen;
        enable = 1'b0;
        set_cfg(1'b0, 8'd0, 2'b01, 5'd3, 1'b1, 1'b0);
        repeat (2) @(negedge clk);
        enable = 1'b1;
        wait_frame(50, seen);
        repeat (5) @(negedge clk);
        enable = 1'b0;
        @(negedge clk);
        chk({bit_clk, bit_rise, word_start, frame_start, frame_sync, cfg_error} == 6'd0,
            "R10 outputs cleared", int'({bit_clk, frame_sync}), 0);
        cfg_modulus = 8'd3;
        @(negedge clk);
        enable = 1'b1;
        wait_frame(100, seen);
        chk(seen, "R10 restart frame", int'(seen), 1);
        cyc = 0; last = 0; n = 0;
        while (seen && n < 2) begin
            @(negedge clk);
            cyc++;
            if (bit_rise) begin
                chk(cyc - last == 16, "R10 new period", cyc - last, 16);
                last = cyc;
                n++;
            end
        end
    endtask

    initial begin
        t_reset();
        t_run(1'b0, 8'd0,   2'b00, 5'd0,  1'b0, 1'b0, 10);
        t_run(1'b0, 8'd0,   2'b01, 5'd1,  1'b1, 1'b0, 22);
        t_run(1'b0, 8'd2,   2'b10, 5'd31, 1'b0, 1'b1, 386);
        t_run(1'b0, 8'd0,   2'b11, 5'd31, 1'b1, 1'b1, 514);
        t_run(1'b1, 8'd0,   2'b11, 5'd1,  1'b1, 1'b1, 34);
        t_run(1'b1, 8'd255, 2'b00, 5'd0,  1'b0, 1'b0, 3);
        t_run(1'b0, 8'd255, 2'b10, 5'd1,  1'b0, 1'b0, 26);
        t_midframe();
        t_illegal();
        t_disable();
        enable = 1'b0;
        repeat (3) @(negedge clk);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule